// File: doc/BRIEF.md
# Sample FIFO with DMA threshold

This block is a receive buffer for converter samples. A producer writes 32-bit samples into a 64-entry first-in first-out store. A processor or a DMA engine drains the store over a small register bus. Reading the data offset removes the oldest sample and returns it. Read data appears on the cycle after the read strobe.

A programmable fill threshold drives a DMA request line while enough samples are waiting. Each DMA acknowledge removes one sample, in the same way as a processor read. A status offset reports the fill count and whether any data is waiting. A sticky overflow output shows that a sample was lost because the store was full.

Top module: `sample_fifo_dma`

## Requirements
- R1: After reset, reads of offsets 0x000, 0x100 and 0x104 return 0x00000000, and dma_req and overflow are 0.
- R2: A read at offset 0x000 removes the oldest stored sample. The sample appears on bus_rdata on the cycle after the strobe, and samples leave in the order they were pushed.
- R3: The store holds 64 samples. A push into a full store in a cycle with no pop is dropped, leaves the count at 64, and sets overflow to 1. Overflow stays at 1 until reset.
- R4: A data read while the store is empty returns 0 and leaves the count at 0.
- R5: Offset 0x100 holds a threshold that software can write and read back in bits 5:0. Its reset value is 0, and bits 31:6 read as 0.
- R6: Offset 0x104 returns the fill count in bits 6:0, which can reach 64 (0x40). Bit 8 is 1 when the count is nonzero and 0 when the store is empty. All other bits read as 0.
- R7: dma_req is 1 exactly when the threshold is nonzero and the current count is at least the threshold.
- R8: A dma_ack pulse removes one sample, and that sample appears on bus_rdata on the next cycle. A dma_ack that arrives in the same cycle as a data read removes only one sample.
- R9: A push and a pop in the same cycle leave the count unchanged and keep sample order. This also holds when the store is full.
- R10: Bus writes to offsets 0x000 and 0x104 have no effect on the contents, the count or the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample push strobe |
| smp_data | input | 32 | Sample value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd or dma_ack |
| dma_ack | input | 1 | DMA acknowledge, pops one sample |
| dma_req | output | 1 | DMA request, high when the threshold is met |
| overflow | output | 1 | Sticky flag for a lost sample |

## Verification
The bench runs several patterns and checks each against a queue of expected samples:
- A short burst with reads in between confirms ordering, the status encoding and the threshold crossing.
- Writes to the read-only offsets, followed by a status read and a data read, show that those writes change nothing.
- A DMA acknowledge on its own, and one that collides with a processor read, tell a single pop apart from a double pop.
- A fill to 64, followed by one extra push, separates a dropped sample from a wrapped pointer.
- A push and a pop in the same cycle, at a partial fill and at a full store, show that the count holds and the order survives a full drain.

// File: rtl/sample_fifo_dma.sv
module sample_fifo_dma #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_THD  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h104);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, thd;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] reg_val;

  wire empty   = (count == '0);
  wire full    = (count == CNT_FULL);
  wire rd_data = bus_rd && (bus_addr == OFS_DATA);
  wire pop_req = rd_data || dma_ack;
  wire pop     = pop_req && !empty;
  wire push    = smp_valid && (!full || pop);

  assign dma_req = (thd != '0) && (count >= {1'b0, thd});

  always_ff @(posedge clk)
    if (push) mem[wptr] <= smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count    <= count + CNT_W'(push) - CNT_W'(pop);
      overflow <= overflow || (smp_valid && !push);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) thd <= '0;
    else if (bus_wr && bus_addr == OFS_THD) thd <= bus_wdata[PTR_W-1:0];
  end

  always_comb begin
    reg_val = '0;
    if (bus_addr == OFS_THD) reg_val[PTR_W-1:0] = thd;
    else if (bus_addr == OFS_STAT) begin
      reg_val[CNT_W-1:0] = count;
      reg_val[8]         = !empty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (pop_req) bus_rdata <= empty ? '0 : mem[rptr];
    else if (bus_rd)  bus_rdata <= reg_val;
  end
endmodule

// File: rtl/sample_fifo_dma_chk.sv
module sample_fifo_dma_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              dma_ack,
  input logic              dma_req,
  input logic              overflow,
  input logic [$clog2(DEPTH):0]   count,
  input logic [$clog2(DEPTH)-1:0] thd
);
  wire rd0 = bus_rd && (bus_addr == '0);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && count == '0 && !smp_valid) |=> (bus_rdata == '0 && count == '0));

  assert_thd_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12'h100)) |=> (thd == $past(bus_wdata[$clog2(DEPTH)-1:0])));

  assert_req_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (count != '0));

  assert_ack_pops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !smp_valid && count != '0) |=> (count == $past(count) - 1'b1));

  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (rd0 || dma_ack) && count != '0) |=> $stable(count));
endmodule

bind sample_fifo_dma sample_fifo_dma_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_ack(dma_ack),
  .dma_req(dma_req), .overflow(overflow), .count(count), .thd(thd)
);

// File: tb/sample_fifo_dma_test.sv
`timescale 1ns/1ps
module sample_fifo_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, dma_ack = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req, overflow;

  int checks = 0, fails = 0;
  logic [31:0] sb [$];
  logic [31:0] exp;

  always #4 clk = ~clk;

  sample_fifo_dma uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_ack(dma_ack), .dma_req(dma_req), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] v, input bit keep);
    @(negedge clk); smp_valid = 1'b1; smp_data = v;
    @(negedge clk); smp_valid = 1'b0;
    if (keep) sb.push_back(v);
  endtask

  task automatic reg_rd(input logic [11:0] a, input string req, input logic [31:0] expv);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    check(req, bus_rdata, expv);
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pop_data(input string req);
    exp = (sb.size() != 0) ? sb.pop_front() : 32'h0;
    reg_rd(12'h000, req, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 dma_req", {31'b0, dma_req}, 0);
    check("R1 overflow", {31'b0, overflow}, 0);
    reg_rd(12'h000, "R1 data", 0);
    reg_rd(12'h100, "R1 thd", 0);
    reg_rd(12'h104, "R1 stat", 0);

    reg_wr(12'h100, 32'hFFFF_FFC5);
    reg_rd(12'h100, "R5 thd readback", 32'h5);

    push(32'hA1, 1); push(32'hA2, 1); push(32'hA3, 1);
    reg_rd(12'h104, "R6 stat count3", 32'h103);
    check("R7 below thd", {31'b0, dma_req}, 0);
    push(32'hA4, 1); push(32'hA5, 1);
    check("R7 at thd", {31'b0, dma_req}, 1);
    pop_data("R2 order 1");
    pop_data("R2 order 2");
    check("R7 fell below", {31'b0, dma_req}, 0);

    reg_wr(12'h000, 32'hDEAD_BEEF);
    reg_wr(12'h104, 32'h0000_0000);
    reg_rd(12'h104, "R10 stat unchanged", 32'h103);
    reg_rd(12'h100, "R10 thd unchanged", 32'h5);

    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    exp = sb.pop_front();
    check("R8 ack data", bus_rdata, exp);
    reg_rd(12'h104, "R8 ack count", 32'h102);
    @(negedge clk); dma_ack = 1'b1; bus_rd = 1'b1; bus_addr = 12'h000;
    @(negedge clk); dma_ack = 1'b0; bus_rd = 1'b0;
    exp = sb.pop_front();
    check("R8 collide data", bus_rdata, exp);
    reg_rd(12'h104, "R8 collide single pop", 32'h101);

    @(negedge clk); smp_valid = 1'b1; smp_data = 32'hB0; bus_rd = 1'b1; bus_addr = 12'h000;
    @(negedge clk); smp_valid = 1'b0; bus_rd = 1'b0;
    exp = sb.pop_front(); sb.push_back(32'hB0);
    check("R9 partial data", bus_rdata, exp);
    reg_rd(12'h104, "R9 partial count", 32'h101);
    pop_data("R9 partial order");
    reg_rd(12'h104, "R6 empty stat", 32'h0);
    reg_rd(12'h000, "R4 empty read", 32'h0);
    reg_rd(12'h104, "R4 count kept", 32'h0);

    for (int i = 0; i < 64; i++) push(32'h1000 + i, 1);
    reg_rd(12'h104, "R6 full stat", 32'h140);
    check("R3 no overflow yet", {31'b0, overflow}, 0);
    push(32'hFFFF, 0);
    check("R3 overflow set", {31'b0, overflow}, 1);
    reg_rd(12'h104, "R3 count held", 32'h140);
    reg_wr(12'h100, 32'h0);
    check("R7 zero thd", {31'b0, dma_req}, 0);
    reg_wr(12'h100, 32'h3F);
    check("R7 full thd63", {31'b0, dma_req}, 1);

    @(negedge clk); smp_valid = 1'b1; smp_data = 32'hC0DE; bus_rd = 1'b1; bus_addr = 12'h000;
    @(negedge clk); smp_valid = 1'b0; bus_rd = 1'b0;
    exp = sb.pop_front(); sb.push_back(32'hC0DE);
    check("R9 full data", bus_rdata, exp);
    reg_rd(12'h104, "R9 full count", 32'h140);
    check("R3 overflow sticky", {31'b0, overflow}, 1);
    for (int i = 0; i < 64; i++) pop_data("R2 drain order");
    reg_rd(12'h104, "R2 drained", 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule